// File: doc/BRIEF.md
# Multirange ADC Serial Command Decoder

This block is the device side of the serial port of a multichannel successive-approximation converter. It watches chip select, SCLK and DIN, finds the start of each command byte, and decodes that byte as one of two things. A configuration write stores a differential flag and a range code for one channel. A conversion command selects a channel and runs a 32-clock frame in external clock mode. During that frame the 16-bit sample from the converter model is shifted out on DOUT, most significant bit first.

All serial pins are sampled by a fast system clock, and SCLK edges are found by comparing the pin with its value one system cycle earlier. Every channel has its own configuration register. Channels pair up as even (positive) and odd (negative) inputs. When the even member of a pair is set to differential, a conversion on either member uses the even channel's configuration. The selected channel, mode and range are driven to the analog side when a conversion command decodes. The strobe output stays low, because only external clock mode is built.

Top module: `adc_cmd_decoder`

## Requirements
- R1: After reset every channel holds single-ended mode with range code 3'b111, `sel_chan`=0, `sel_diff`=0, `sel_range`=3'b111, and `dout` and `dout_oe` are 0.
- R2: While chip select is low and no byte is in progress, zeros on DIN are skipped. The first 1 sampled is the start bit of an 8-bit command byte, and leading zero bits have no effect on the result.
- R3: DIN is sampled only on rising SCLK edges, and `dout` changes only on falling SCLK edges or when chip select is high. The selected channel, mode and range change only on the rising edge that completes a conversion byte.
- R4: While `cs_n` is high, `dout_oe` is 0, `dout` is 0, and SCLK and DIN activity writes no configuration and starts no conversion.
- R5: The command byte is sent MSB first as bit7 = start (1), bits 6:4 = channel, bit3 = differential flag (1 = differential), bits 2:0 = range code. A byte with a nonzero range code stores {differential flag, range code} into that channel's register.
- R6: A byte with range code 3'b000 is a conversion command. On its 8th rising edge, `sel_chan`, `sel_diff` and `sel_range` take the addressed channel's stored setting.
- R7: If the even channel of a pair (channel with bit0 cleared) stores differential = 1, a conversion on either member of the pair selects the even channel, `sel_diff`=1 and the even channel's range. Otherwise the addressed channel is selected as single-ended with its own range, even if it stores a differential flag.
- R8: In a conversion frame, `sample_in` is loaded on the falling edge after rising edge 16. DOUT then carries B15, and each later falling edge moves on by one bit, so B15..B0 are read on rising edges 17..32. After the falling edge that follows rising edge 32, `dout` returns to 0 and the decoder hunts for a new start bit.
- R9: `sstrb` is 0 at all times, whatever the state of chip select.
- R10: If chip select rises partway through a byte or frame, that byte or frame is abandoned. The next frame decodes from a fresh start bit.
- R11: After a configuration byte the decoder hunts for a new start bit right away, so a conversion byte can follow in the same chip-select window and already sees the new setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data from the host |
| sample_in | input | 16 | Parallel result from the converter model |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for DOUT; 0 means high impedance |
| sstrb | output | 1 | Serial strobe, held low in external clock mode |
| sel_chan | output | 3 | Channel selected for the conversion |
| sel_diff | output | 1 | 1 when the selection is a differential pair |
| sel_range | output | 3 | Range code applied to the conversion |

## Verification
A rising or falling SCLK edge takes effect one system clock after the pin changes. The bench holds each SCLK level for four system clocks and samples DOUT just before it raises SCLK again, so the bit it reads is the one loaded by the previous falling edge: B15 is read in serial bit 17 and B0 in bit 32. The selection outputs change one system clock after the 8th rising edge and are checked only after the whole frame has ended. The idle value of DOUT after the last falling edge is read three system clocks later, while chip select is still low.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;

    localparam int CMD_W  = 8;
    localparam int CHF_W  = 3;
    localparam int RNG_W  = 3;

    typedef struct packed {
        logic             diff;
        logic [RNG_W-1:0] rng;
    } ch_cfg_t;

    typedef struct packed {
        logic             start;
        logic [CHF_W-1:0] chan;
        logic             diff;
        logic [RNG_W-1:0] rng;
    } cmd_byte_t;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_BYTE = 2'd1,
        ST_CONV = 2'd2
    } frm_state_t;

    localparam ch_cfg_t CFG_RESET = '{diff: 1'b0, rng: 3'b111};

    function automatic logic is_conv(input cmd_byte_t b);
        return (b.rng == '0);
    endfunction

    function automatic logic [CHF_W-1:0] pair_head(input logic [CHF_W-1:0] ch);
        return {ch[CHF_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    always_comb begin
        rise = !cs_n &&  sclk && !sclk_q;
        fall = !cs_n && !sclk &&  sclk_q;
    end
endmodule

// File: rtl/cmd_frame_seq.sv
module cmd_frame_seq
    import adc_cmd_pkg::*;
#(
    parameter int FRAME_LEN = 32,
    parameter int RES_W     = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      rise,
    input  logic      fall,
    input  logic      din,
    output logic      cmd_valid,
    output cmd_byte_t cmd,
    output logic      load_res,
    output logic      shift_res,
    output logic      end_res
);
    localparam int CNT_W   = $clog2(FRAME_LEN + 1);
    localparam int LOAD_AT = FRAME_LEN - RES_W;
    localparam int LAST_IN = CMD_W - 1;

    frm_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CMD_W-3:0]  shreg;
    logic              byte_done;

    always_comb begin
        cmd       = {1'b1, shreg, din};
        byte_done = (state == ST_BYTE) && rise && (bit_cnt == CNT_W'(LAST_IN));
        cmd_valid = byte_done;
        load_res  = (state == ST_CONV) && fall && (bit_cnt == CNT_W'(LOAD_AT));
        shift_res = (state == ST_CONV) && fall && (bit_cnt > CNT_W'(LOAD_AT))
                    && (bit_cnt < CNT_W'(FRAME_LEN));
        end_res   = (state == ST_CONV) && fall && (bit_cnt == CNT_W'(FRAME_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            state   <= ST_HUNT;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (rise && din) begin
                        state   <= ST_BYTE;
                        bit_cnt <= CNT_W'(1);
                        shreg   <= '0;
                    end
                end
                ST_BYTE: begin
                    if (rise) begin
                        shreg   <= {shreg[CMD_W-4:0], din};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (byte_done) begin
                            if (is_conv(cmd)) begin
                                state <= ST_CONV;
                            end else begin
                                state   <= ST_HUNT;
                                bit_cnt <= '0;
                            end
                        end
                    end
                end
                ST_CONV: begin
                    if (rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (end_res) begin
                        state   <= ST_HUNT;
                        bit_cnt <= '0;
                    end
                end
                default: begin
                    state   <= ST_HUNT;
                    bit_cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ch_cfg_bank.sv
module ch_cfg_bank
    import adc_cmd_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CHF_W-1:0] wr_chan,
    input  ch_cfg_t          wr_cfg,
    input  logic [CHF_W-1:0] rd_chan,
    output logic [CHF_W-1:0] eff_chan,
    output ch_cfg_t          eff_cfg
);
    ch_cfg_t regs [N_CH];

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)                                    regs[g] <= CFG_RESET;
            else if (wr_en && wr_chan == CHF_W'(g))     regs[g] <= wr_cfg;
        end
    end

    function automatic ch_cfg_t lookup(input logic [CHF_W-1:0] idx);
        ch_cfg_t r;
        r = CFG_RESET;
        for (int i = 0; i < N_CH; i++) begin
            if (idx == CHF_W'(i)) r = regs[i];
        end
        return r;
    endfunction

    logic [CHF_W-1:0] head;
    ch_cfg_t          head_cfg;
    ch_cfg_t          own_cfg;

    always_comb begin
        head     = pair_head(rd_chan);
        head_cfg = lookup(head);
        own_cfg  = lookup(rd_chan);
        if (head_cfg.diff) begin
            eff_chan = head;
            eff_cfg  = head_cfg;
        end else begin
            eff_chan     = rd_chan;
            eff_cfg.diff = 1'b0;
            eff_cfg.rng  = own_cfg.rng;
        end
    end
endmodule

// File: rtl/result_shifter.sv
module result_shifter #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             load,
    input  logic             shift,
    input  logic             stop,
    input  logic [RES_W-1:0] sample,
    output logic             dout
);
    logic [RES_W-1:0] data;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            data   <= '0;
            active <= 1'b0;
        end else if (load) begin
            data   <= sample;
            active <= 1'b1;
        end else if (shift) begin
            data   <= {data[RES_W-2:0], 1'b0};
        end else if (stop) begin
            data   <= '0;
            active <= 1'b0;
        end
    end

    assign dout = active && data[RES_W-1];
endmodule

// File: rtl/adc_cmd_decoder.sv
module adc_cmd_decoder
    import adc_cmd_pkg::*;
#(
    parameter int N_CH      = 8,
    parameter int RES_W     = 16,
    parameter int FRAME_LEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] sample_in,
    output logic             dout,
    output logic             dout_oe,
    output logic             sstrb,
    output logic [CHF_W-1:0] sel_chan,
    output logic             sel_diff,
    output logic [RNG_W-1:0] sel_range
);
    logic      rise, fall;
    logic      cmd_valid;
    cmd_byte_t cmd;
    logic      load_res, shift_res, end_res;
    logic      conv_hit, cfg_hit;
    logic [CHF_W-1:0] eff_chan;
    ch_cfg_t          eff_cfg;
    ch_cfg_t          wr_cfg;

    sclk_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    cmd_frame_seq #(.FRAME_LEN(FRAME_LEN), .RES_W(RES_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rise      (rise),
        .fall      (fall),
        .din       (din),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .load_res  (load_res),
        .shift_res (shift_res),
        .end_res   (end_res)
    );

    always_comb begin
        conv_hit    = cmd_valid &&  is_conv(cmd);
        cfg_hit     = cmd_valid && !is_conv(cmd);
        wr_cfg.diff = cmd.diff;
        wr_cfg.rng  = cmd.rng;
    end

    ch_cfg_bank #(.N_CH(N_CH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_hit),
        .wr_chan  (cmd.chan),
        .wr_cfg   (wr_cfg),
        .rd_chan  (cmd.chan),
        .eff_chan (eff_chan),
        .eff_cfg  (eff_cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_chan  <= '0;
            sel_diff  <= CFG_RESET.diff;
            sel_range <= CFG_RESET.rng;
        end else if (conv_hit) begin
            sel_chan  <= eff_chan;
            sel_diff  <= eff_cfg.diff;
            sel_range <= eff_cfg.rng;
        end
    end

    result_shifter #(.RES_W(RES_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .load   (load_res),
        .shift  (shift_res),
        .stop   (end_res),
        .sample (sample_in),
        .dout   (dout)
    );

    assign dout_oe = !cs_n;
    assign sstrb   = 1'b0;
endmodule

// File: rtl/adc_cmd_decoder_chk.sv
module adc_cmd_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic       dout,
    input logic [2:0] sel_chan,
    input logic       sel_diff,
    input logic [2:0] sel_range,
    input logic       conv_hit
);
    AST_DOUT_QUIET_DESELECT: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !dout);  // R4

    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> ($past(cs_n) || (!$past(sclk) && $past(sclk, 2))));  // R3

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !conv_hit |=> $stable({sel_chan, sel_diff, sel_range}));  // R6

    AST_SEL_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        conv_hit |-> (sclk && !$past(sclk) && !cs_n));  // R3

    AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (rst)
        sel_diff |-> !sel_chan[0]);  // R7
endmodule

bind adc_cmd_decoder adc_cmd_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .dout      (dout),
    .sel_chan  (sel_chan),
    .sel_diff  (sel_diff),
    .sel_range (sel_range),
    .conv_hit  (conv_hit)
);

// File: tb/adc_cmd_decoder_bench.sv
module adc_cmd_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [15:0] sample_in = '0;
    logic        dout, dout_oe, sstrb, sel_diff;
    logic [2:0]  sel_chan, sel_range;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    bit sstrb_seen_high = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    adc_cmd_decoder u_adc_cmd_decoder (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe), .sstrb(sstrb),
        .sel_chan(sel_chan), .sel_diff(sel_diff), .sel_range(sel_range)
    );

    typedef struct packed {
        logic [7:0]  cfg_cmd;
        logic [7:0]  conv_cmd;
        logic [15:0] smp;
        logic [2:0]  e_chan;
        logic        e_diff;
        logic [2:0]  e_rng;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 8'h80, 16'hA5C3, 3'd0, 1'b0, 3'b111},
        '{8'hAC, 8'hA0, 16'h8001, 3'd2, 1'b1, 3'b100},
        '{8'h00, 8'hB0, 16'h7FFE, 3'd2, 1'b1, 3'b100},
        '{8'hD2, 8'hD0, 16'hFFFF, 3'd5, 1'b0, 3'b010},
        '{8'hC1, 8'hD0, 16'h0000, 3'd5, 1'b0, 3'b010},
        '{8'hCE, 8'hD0, 16'h1234, 3'd4, 1'b1, 3'b110},
        '{8'hFB, 8'hF0, 16'hC0DE, 3'd7, 1'b0, 3'b011},
        '{8'h95, 8'h90, 16'h5A5A, 3'd1, 1'b0, 3'b101}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (sstrb !== 1'b0) sstrb_seen_high = 1'b1;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic xfer(input logic b, output logic o);
        din = b;
        repeat (4) @(negedge clk);
        o = dout;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic run_frame(input bit has_pre, input logic [7:0] pre, input int lead,
                             input logic [7:0] cmd, input logic [15:0] smp,
                             output logic [15:0] res, output logic oe_seen,
                             output logic tail);
        logic o;
        res = '0;
        sample_in = smp;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        oe_seen = dout_oe;
        if (has_pre) for (int i = 7; i >= 0; i--) xfer(pre[i], o);
        for (int i = 0; i < lead; i++) xfer(1'b0, o);
        for (int k = 1; k <= 32; k++) begin
            xfer((k <= 8) ? cmd[8-k] : 1'b0, o);
            if (k >= 17) res[32-k] = o;
        end
        repeat (3) @(negedge clk);
        tail = dout;
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] cmd);
        logic o;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 7; i >= 0; i--) xfer(cmd[i], o);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [15:0] res;
        logic oe, tail, o;
        bit oe_bad, dout_bad;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        check("R1 sel_chan", 16'(sel_chan), 16'd0);
        check("R1 sel_diff", 16'(sel_diff), 16'd0);
        check("R1 sel_range", 16'(sel_range), 16'd7);
        check("R1 dout", 16'(dout), 16'd0);
        check("R4 dout_oe idle", 16'(dout_oe), 16'd0);

        // table walk: R5 R6 R7 R8
        for (int v = 0; v < 8; v++) begin
            if (VECS[v].cfg_cmd != 8'h00) write_cfg(VECS[v].cfg_cmd);
            run_frame(1'b0, 8'h00, 0, VECS[v].conv_cmd, VECS[v].smp, res, oe, tail);
            check($sformatf("R6 R7 vec%0d chan", v), 16'(sel_chan), 16'(VECS[v].e_chan));
            check($sformatf("R5 R7 vec%0d diff", v), 16'(sel_diff), 16'(VECS[v].e_diff));
            check($sformatf("R5 R6 vec%0d range", v), 16'(sel_range), 16'(VECS[v].e_rng));
            check($sformatf("R8 vec%0d result", v), res, VECS[v].smp);
        end

        // R2: leading zeros before the start bit
        run_frame(1'b0, 8'h00, 3, 8'h90, 16'h3C3C, res, oe, tail);
        check("R2 lead chan", 16'(sel_chan), 16'd1);
        check("R2 lead range", 16'(sel_range), 16'd5);
        check("R2 lead result", res, 16'h3C3C);
        check("R4 dout_oe selected", 16'(oe), 16'd1);
        check("R8 dout idle after frame", 16'(tail), 16'd0);

        // R4: activity with chip select high is ignored
        oe_bad = 1'b0;
        dout_bad = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            xfer(8'hEA >> i, o);
            if (dout_oe !== 1'b0) oe_bad = 1'b1;
            if (dout !== 1'b0) dout_bad = 1'b1;
        end
        check("R4 oe low while deselected", 16'(oe_bad), 16'd0);
        check("R4 dout low while deselected", 16'(dout_bad), 16'd0);
        run_frame(1'b0, 8'h00, 0, 8'hE0, 16'h9696, res, oe, tail);
        check("R4 ch6 diff untouched", 16'(sel_diff), 16'd0);
        check("R4 ch6 range untouched", 16'(sel_range), 16'd7);
        check("R4 ch6 chan", 16'(sel_chan), 16'd6);

        // R10: abandoned partial byte
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        xfer(1'b1, o); xfer(1'b0, o); xfer(1'b0, o); xfer(1'b0, o);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        run_frame(1'b0, 8'h00, 0, 8'hE0, 16'h0F0F, res, oe, tail);
        check("R10 after abandon chan", 16'(sel_chan), 16'd6);
        check("R10 after abandon diff", 16'(sel_diff), 16'd0);
        check("R10 after abandon range", 16'(sel_range), 16'd7);
        check("R10 after abandon result", res, 16'h0F0F);

        // R11: config then conversion in one chip-select window
        run_frame(1'b1, 8'h8F, 0, 8'h90, 16'h6E6E, res, oe, tail);
        check("R11 pair chan", 16'(sel_chan), 16'd0);
        check("R11 pair diff", 16'(sel_diff), 16'd1);
        check("R11 pair range", 16'(sel_range), 16'd7);
        check("R11 result", res, 16'h6E6E);
        check("R8 dout idle tail", 16'(tail), 16'd0);

        check("R9 sstrb never high", 16'(sstrb_seen_high), 16'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule